// File: doc/BRIEF.md
# Length-Prefixed Message Field Extractor

This block sits on a byte stream that carries back-to-back messages, one byte on each cycle where the input is valid. Every message opens with a two-byte length prefix. The block counts bytes against that prefix to find where each message ends. On the way it picks up a one-byte type code and a 32-bit seconds value, both at fixed positions. It pulses a completion strobe once for every message it finishes.

When a finished message carries the single type code the block is built to accept, the block places its seconds value on a 32-bit output stream with a valid/ready handshake. All other messages are consumed in full and produce no output. While an output word waits for the consumer, the input is stalled, so no value is ever lost.

Top module: `msg_field_extractor`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the byte position, drops any partly received message, and leaves in_ready=1, out_valid=0 and msg_done=0 on the cycle after reset.
- R2: Byte 0 (most significant) and byte 1 of a message form a big-endian length L. L counts the bytes that follow the prefix, so a message spans L+2 bytes, and the next accepted byte is byte 0 of the next message.
- R3: msg_done is high for exactly one cycle, the cycle after the final byte of a message is accepted. This includes L=0, where the final byte is byte 1.
- R4: Byte 2 is the type code. Bytes 3 to 6 form the 32-bit seconds value, with byte 3 as bits 31:24 and byte 6 as bits 7:0.
- R5: If the type code equals MATCH_TYPE (default 8'h54) and L>=5, out_valid rises with out_data equal to the seconds value in the same cycle as msg_done. Exactly one word is emitted for that message.
- R6: A message whose type code differs from MATCH_TYPE produces no output word.
- R7: A message with L<5 produces no output word, even when its type byte matches.
- R8: While out_valid=1 and out_ready=0, out_valid and out_data stay unchanged and in_ready is 0. In every other case in_ready is 1.
- R9: A cycle with in_valid=0 consumes no byte, and in_data is ignored on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | in_data holds a byte |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| out_valid | output | 1 | out_data holds a seconds word |
| out_data | output | 32 | Extracted seconds value |
| out_ready | input | 1 | Consumer takes the word this cycle |
| msg_done | output | 1 | One-cycle pulse at the end of each message |

## Verification
in_ready is combinational from out_valid and out_ready. It is due in the same cycle as those signals, so the bench checks it 1 ns after driving inputs at the falling edge, before the next rising edge. msg_done, out_valid and out_data all come from one register stage. They are due one cycle after the rising edge that accepts the final byte of a message. The bench records each handshake it sees before a rising edge, then compares these outputs at the following falling edge. Stalled output words are checked for stability at each falling edge for as long as out_ready stays low.

// File: rtl/msg_field_extractor.sv
module msg_field_extractor #(
  parameter logic [7:0] MATCH_TYPE = 8'h54,
  parameter int         LEN_W      = 16,
  parameter int         MIN_LEN    = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        out_valid,
  output logic [31:0] out_data,
  input  logic        out_ready,
  output logic        msg_done
);
  localparam int CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] pos;
  logic [7:0]       len_hi;
  logic [LEN_W-1:0] len;
  logic [7:0]       kind;
  logic [31:0]      secs;

  wire              take     = in_valid && in_ready;
  wire [LEN_W-1:0]  len_now  = {len_hi, in_data};
  wire [CNT_W-1:0]  last_pos = {1'b0, len} + CNT_W'(1);
  wire              at_end   = (pos == CNT_W'(1)) ? (len_now == '0)
                                                  : (pos >= CNT_W'(2) && pos == last_pos);
  wire [31:0]       sec_now  = (pos == CNT_W'(6)) ? {secs[23:0], in_data} : secs;
  wire              hit      = (len >= LEN_W'(MIN_LEN)) && (kind == MATCH_TYPE);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos       <= '0;
      len_hi    <= '0;
      len       <= '0;
      kind      <= '0;
      secs      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      msg_done  <= 1'b0;
    end else begin
      msg_done <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take) begin
        pos <= pos + CNT_W'(1);
        if (pos == CNT_W'(0)) len_hi <= in_data;
        if (pos == CNT_W'(1)) len    <= len_now;
        if (pos == CNT_W'(2)) kind   <= in_data;
        if (pos >= CNT_W'(3) && pos <= CNT_W'(6)) secs <= {secs[23:0], in_data};
        if (at_end) begin
          pos      <= '0;
          msg_done <= 1'b1;
          if (pos != CNT_W'(1) && hit) begin
            out_valid <= 1'b1;
            out_data  <= sec_now;
          end
        end
      end
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pos == '0 && !out_valid && !msg_done));

  a_r2_pos_bound: assert property (@(posedge clk) disable iff (rst)
    (pos >= CNT_W'(2)) |-> (pos <= last_pos));

  a_r3_done_restarts: assert property (@(posedge clk) disable iff (rst)
    msg_done |-> (pos == '0));

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    msg_done |=> !msg_done);

  a_r5_word_on_done: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> msg_done);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r9_idle_no_advance: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(pos));
endmodule

// File: tb/msg_field_extractor_test.sv
module msg_field_extractor_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        out_ready = 1'b0;
  logic        in_ready, out_valid, msg_done;
  logic [31:0] out_data;

  int vectors = 0;
  int fails   = 0;

  logic [7:0]  bq[$];
  bit          lq[$];
  logic [31:0] eq[$];
  bit          exp_done = 1'b0;
  bit          hold_chk = 1'b0;
  logic [31:0] held = '0;

  always #2 clk = ~clk;

  msg_field_extractor uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .msg_done(msg_done)
  );

  function automatic bit emits(input logic [15:0] l, input logic [7:0] t);
    return (t == 8'h54) && (l >= 16'd5);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic add_msg(input logic [15:0] l, input logic [7:0] t, input logic [31:0] s);
    bq.push_back(l[15:8]); lq.push_back(1'b0);
    bq.push_back(l[7:0]);  lq.push_back(l == 16'd0);
    for (int i = 0; i < int'(l); i++) begin
      logic [7:0] b;
      case (i)
        0: b = t;
        1: b = s[31:24];
        2: b = s[23:16];
        3: b = s[15:8];
        4: b = s[7:0];
        default: b = 8'($urandom);
      endcase
      bq.push_back(b);
      lq.push_back(i == int'(l) - 1);
    end
    if (emits(l, t)) eq.push_back(s);
  endtask

  task automatic run(input int idle_pct, input int stall_pct);
    while (bq.size() > 0 || eq.size() > 0 || exp_done) begin
      @(negedge clk);
      chk(msg_done === exp_done, "R3 R2 R9 msg_done", 32'(msg_done), 32'(exp_done));
      if (hold_chk)
        chk(out_valid === 1'b1 && out_data === held, "R8 hold", out_data, held);
      exp_done = 1'b0;
      out_ready = ($urandom % 100) >= 32'(stall_pct);
      if (bq.size() > 0 && ($urandom % 100) >= 32'(idle_pct)) begin
        in_valid = 1'b1; in_data = bq[0];
      end else begin
        in_valid = 1'b0; in_data = 8'($urandom);
      end
      #1;
      chk(in_ready === (!out_valid || out_ready), "R8 in_ready", 32'(in_ready), 32'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (eq.size() == 0) chk(1'b0, "R6 R7 stray word", out_data, 32'h0);
        else begin
          chk(out_data === eq[0], "R4 R5 seconds", out_data, eq[0]);
          void'(eq.pop_front());
        end
      end
      hold_chk = out_valid && !out_ready;
      held = out_data;
      if (in_valid && in_ready) begin
        exp_done = lq[0];
        void'(bq.pop_front());
        void'(lq.pop_front());
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    hold_chk = 1'b0;
    #1;
    chk(out_valid === 1'b0, "R6 R7 no extra word", 32'(out_valid), 32'h0);
    @(negedge clk);
  endtask

  task automatic check_reset();
    chk(in_ready === 1'b1, "R1 in_ready", 32'(in_ready), 32'h1);
    chk(out_valid === 1'b0, "R1 out_valid", 32'(out_valid), 32'h0);
    chk(msg_done === 1'b0, "R1 msg_done", 32'(msg_done), 32'h0);
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL R2 watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset();

    add_msg(16'd5, 8'h54, 32'h12345678);
    add_msg(16'd0, 8'h54, 32'h0);
    add_msg(16'd4, 8'h54, 32'hDEADBEEF);
    add_msg(16'd8, 8'h41, 32'h0BADF00D);
    add_msg(16'd6, 8'h74, 32'h01020304);
    add_msg(16'd5, 8'h54, 32'hFFFFFFFF);
    add_msg(16'd1, 8'h54, 32'h0);
    add_msg(16'd40, 8'h54, 32'hA5A55A5A);
    add_msg(16'd7, 8'h54, 32'h00000001);
    run(0, 0);

    bq.push_back(8'h00); lq.push_back(1'b0);
    bq.push_back(8'h08); lq.push_back(1'b0);
    bq.push_back(8'h54); lq.push_back(1'b0);
    bq.push_back(8'h11); lq.push_back(1'b0);
    run(0, 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset();
    add_msg(16'd5, 8'h54, 32'hCAFEF00D);
    run(0, 0);

    for (int i = 0; i < 300; i++) begin
      logic [7:0] t;
      t = (($urandom % 10) < 6) ? 8'h54 : 8'($urandom);
      add_msg(16'($urandom % 15), t, $urandom);
    end
    run(30, 50);

    for (int i = 0; i < 200; i++)
      add_msg(16'($urandom % 12), (($urandom % 2) == 0) ? 8'h54 : 8'h55, $urandom);
    run(0, 0);

    for (int i = 0; i < 50; i++)
      add_msg(16'd5, 8'h54, $urandom);
    run(0, 90);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule